// File: doc/BRIEF.md
# Multiply-Divide Accumulator Unit

This block is the arithmetic side unit of a processor core that owns a double-width accumulator. The accumulator is split into a high word (HI) and a low word (LO). The unit handles four kinds of work, and all of them share that one HI/LO pair:

- **Full-width multiplies.** Each one either replaces the accumulator or is added to it or subtracted from it.
- **Iterative divides.** A divide leaves the quotient in LO and the remainder in HI.
- **A short multiply.** Its low product word goes back to the caller.
- **Direct moves.** These write or read either half of the accumulator.

Requests arrive on a valid/ready channel that carries an operation code and two operand words. The unit accepts one request at a time. It drops `req_ready` in two cases:

- while a multiply or divide is in flight;
- while a returned word has not yet been taken.

Because of this, a read of HI or LO that is issued behind a long divide waits at the request port until the divide has written its result. Words flow back on a valid/ready result channel. A held result keeps its data stable until `res_ready` is seen high at a clock edge, and the sink may stall it for any number of cycles. `busy` is a plain status pin that is high while an arithmetic operation is in flight.

Top module: `mdu_acc_unit`

## Requirements
- R1: After reset, HI and LO read as zero, `busy` and `res_valid` are low, and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The op codes are:
  - 0: signed multiply
  - 1: unsigned multiply
  - 2: signed multiply-add
  - 3: unsigned multiply-add
  - 4: signed multiply-subtract
  - 5: unsigned multiply-subtract
  - 6: signed divide
  - 7: unsigned divide
  - 8: short multiply
  - 9: write HI
  - 10: write LO
  - 11: read HI
  - 12: read LO
- R3: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_data` does not change, and `req_ready` stays low.
- R4: Signed and unsigned multiplies replace {HI,LO} with the full 2*DATA_W-bit product. `busy` is high for exactly MUL_LAT cycles after acceptance.
- R5: Multiply-add adds the full product to {HI,LO}, and multiply-subtract subtracts it from {HI,LO}. Both wrap modulo 2^(2*DATA_W), in signed and unsigned forms.
- R6: The short multiply (code 8) presents the low DATA_W bits of the signed product on `res_data`, MUL_LAT cycles after acceptance. HI and LO are left unchanged.
- R7: An unsigned divide writes the quotient to LO and the remainder to HI. `busy` is high for exactly DATA_W cycles.
- R8: A signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend. The most negative dividend divided by -1 gives quotient equal to the most negative value and remainder 0.
- R9: A divide by zero, signed or unsigned, completes normally. It leaves LO all ones and HI equal to the dividend bits.
- R10: Write-HI and write-LO load the `req_a` word into one half on the accepting edge. The other half is unchanged and `busy` stays low.
- R11: Read-HI and read-LO return the current half on `res_data` one edge after acceptance. While `busy` is high, `req_ready` is low, so a read waits for the operation in flight.
- R12: Op codes 13 to 15 are accepted and change neither HI, LO nor the result channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 4 | Operation code (see R2) |
| req_a | input | DATA_W | First operand / word to write |
| req_b | input | DATA_W | Second operand (multiplier or divisor) |
| busy | output | 1 | Multiply or divide in flight |
| res_valid | output | 1 | Returned word present |
| res_ready | input | 1 | Sink takes the returned word |
| res_data | output | DATA_W | Returned word |

## Verification
Each result lands at a fixed edge counted from the accepting edge:

| Operation | HI/LO or result written at |
|---|---|
| Write-HI, write-LO | the accepting edge |
| Read-HI, read-LO | `res_data` valid one edge after acceptance |
| Multiply, short multiply | edge MUL_LAT after acceptance |
| Divide | edge DATA_W after acceptance |

The bench counts, at the falling edge, how many cycles `busy` stays high after each acceptance and compares that count with the due latency. It reads HI and LO back only once `req_ready` has returned, so every arithmetic check looks at the settled state. Operands are swept over a small 8-bit configuration: every dividend against a set of awkward divisors, plus a grid of multiply pairs. All expected values are computed with wide integer arithmetic in the bench.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULS  = 4'd0,
    OP_MULU  = 4'd1,
    OP_MACS  = 4'd2,
    OP_MACU  = 4'd3,
    OP_MSBS  = 4'd4,
    OP_MSBU  = 4'd5,
    OP_DIVS  = 4'd6,
    OP_DIVU  = 4'd7,
    OP_MULW  = 4'd8,
    OP_PUTHI = 4'd9,
    OP_PUTLO = 4'd10,
    OP_GETHI = 4'd11,
    OP_GETLO = 4'd12
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } mdu_state_e;

  // What to do with a product once the multiplier hands it back
  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2,
    ACC_RET  = 2'd3
  } acc_mode_e;

endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           is_signed,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_prod
);
  localparam int PW = 2 * W;

  logic signed [W:0]    ext_a, ext_b;
  logic signed [PW+1:0] full;
  logic [PW-1:0]        stg_p [LAT];
  logic [LAT-1:0]       stg_v;

  // One extra bit per operand selects signed or unsigned interpretation
  always_comb begin
    ext_a = {is_signed & op_a[W-1], op_a};
    ext_b = {is_signed & op_b[W-1], op_b};
    full  = ext_a * ext_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= '0;
    end else begin
      stg_v[0] <= in_valid;
      for (int i = 1; i < LAT; i++) stg_v[i] <= stg_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) stg_p[0] <= full[PW-1:0];
    for (int i = 1; i < LAT; i++) stg_p[i] <= stg_p[i-1];
  end

  assign out_valid = stg_v[LAT-1];
  assign out_prod  = stg_p[LAT-1];

  // only one product may travel the pipe at a time
  assert_mul_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stg_v));

endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q, raw_q;
  logic          qneg_q, rneg_q, zero_q;

  logic          a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;
  logic [W:0]    shifted, trial;
  logic          take;
  logic [W-1:0]  rem_nx, quo_nx;

  always_comb begin
    a_neg = is_signed & dividend[W-1];
    b_neg = is_signed & divisor[W-1];
    a_mag = a_neg ? (~dividend + 1'b1) : dividend;
    b_mag = b_neg ? (~divisor + 1'b1) : divisor;
  end

  // one restoring step per cycle: shift in next dividend bit, try subtract
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    take    = ~trial[W];
    rem_nx  = take ? trial[W-1:0] : shifted[W-1:0];
    quo_nx  = {quo_q[W-2:0], take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      raw_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      cnt_q  <= CW'(W - 1);
      rem_q  <= '0;
      quo_q  <= a_mag;
      dvs_q  <= b_mag;
      raw_q  <= dividend;
      qneg_q <= a_neg ^ b_neg;
      rneg_q <= a_neg;
      zero_q <= (divisor == '0);
    end else if (run_q) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = run_q;
  assign done = run_q && (cnt_q == '0);
  assign quo  = zero_q ? '1    : (qneg_q ? (~quo_nx + 1'b1) : quo_nx);
  assign rem  = zero_q ? raw_q : (rneg_q ? (~rem_nx + 1'b1) : rem_nx);

  // the partial remainder never reaches the divisor magnitude
  assert_div_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !zero_q) |-> (rem_q < dvs_q));

  assert_div_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q);

endmodule

// File: rtl/mdu_acc_unit.sv
module mdu_acc_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MUL_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [DATA_W-1:0] req_a,
  input  logic [DATA_W-1:0] req_b,
  output logic              busy,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  localparam int AW = 2 * DATA_W;

  mdu_state_e        state_q;
  acc_mode_e         mode_q;
  logic [DATA_W-1:0] hi_q, lo_q, res_q;
  logic              rv_q;

  logic              fire;
  mdu_op_e           op;
  logic              mul_go, mul_sgn, div_go, div_sgn;
  acc_mode_e         mode_d;

  logic              mul_ov;
  logic [AW-1:0]     mul_p;
  logic [AW-1:0]     acc_now;

  logic              div_busy, div_done;
  logic [DATA_W-1:0] div_q, div_r;

  assign op        = mdu_op_e'(req_op);
  assign req_ready = (state_q == ST_IDLE) && !rv_q;
  assign fire      = req_valid && req_ready;
  assign busy      = (state_q != ST_IDLE);
  assign res_valid = rv_q;
  assign res_data  = res_q;
  assign acc_now   = {hi_q, lo_q};

  always_comb begin
    mul_go  = 1'b0;
    mul_sgn = 1'b0;
    div_go  = 1'b0;
    div_sgn = 1'b0;
    mode_d  = ACC_LOAD;
    unique case (op)
      OP_MULS: begin mul_go = fire; mul_sgn = 1'b1; mode_d = ACC_LOAD; end
      OP_MULU: begin mul_go = fire;                 mode_d = ACC_LOAD; end
      OP_MACS: begin mul_go = fire; mul_sgn = 1'b1; mode_d = ACC_ADD;  end
      OP_MACU: begin mul_go = fire;                 mode_d = ACC_ADD;  end
      OP_MSBS: begin mul_go = fire; mul_sgn = 1'b1; mode_d = ACC_SUB;  end
      OP_MSBU: begin mul_go = fire;                 mode_d = ACC_SUB;  end
      OP_MULW: begin mul_go = fire; mul_sgn = 1'b1; mode_d = ACC_RET;  end
      OP_DIVS: begin div_go = fire; div_sgn = 1'b1; end
      OP_DIVU: begin div_go = fire;                 end
      default: ;
    endcase
  end

  mdu_mult #(.W(DATA_W), .LAT(MUL_LAT)) u_mult (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mul_go),
    .is_signed (mul_sgn),
    .op_a      (req_a),
    .op_b      (req_b),
    .out_valid (mul_ov),
    .out_prod  (mul_p)
  );

  mdu_div #(.W(DATA_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_go),
    .is_signed (div_sgn),
    .dividend  (req_a),
    .divisor   (req_b),
    .busy      (div_busy),
    .done      (div_done),
    .quo       (div_q),
    .rem       (div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= ACC_LOAD;
      hi_q    <= '0;
      lo_q    <= '0;
      res_q   <= '0;
      rv_q    <= 1'b0;
    end else begin
      if (rv_q && res_ready) rv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            unique case (op)
              OP_PUTHI: hi_q <= req_a;
              OP_PUTLO: lo_q <= req_a;
              OP_GETHI: begin res_q <= hi_q; rv_q <= 1'b1; end
              OP_GETLO: begin res_q <= lo_q; rv_q <= 1'b1; end
              OP_DIVS, OP_DIVU: state_q <= ST_DIV;
              OP_MULS, OP_MULU, OP_MACS, OP_MACU,
              OP_MSBS, OP_MSBU, OP_MULW: begin
                state_q <= ST_MUL;
                mode_q  <= mode_d;
              end
              default: ;
            endcase
          end
        end
        ST_MUL: begin
          if (mul_ov) begin
            state_q <= ST_IDLE;
            unique case (mode_q)
              ACC_LOAD: {hi_q, lo_q} <= mul_p;
              ACC_ADD:  {hi_q, lo_q} <= acc_now + mul_p;
              ACC_SUB:  {hi_q, lo_q} <= acc_now - mul_p;
              ACC_RET:  begin res_q <= mul_p[DATA_W-1:0]; rv_q <= 1'b1; end
              default: ;
            endcase
          end
        end
        ST_DIV: begin
          if (div_done) begin
            state_q <= ST_IDLE;
            hi_q    <= div_r;
            lo_q    <= div_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_res_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_puthi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PUTHI) |=> (hi_q == $past(req_a) && $stable(lo_q)));

  assert_putlo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PUTLO) |=> (lo_q == $past(req_a) && $stable(hi_q)));

  assert_div_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV) |-> div_busy);

  assert_mul_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_ov |-> (state_q == ST_MUL));

  assert_mulw_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_ov && mode_q == ACC_RET) |=> $stable(acc_now));

endmodule

// File: tb/mdu_acc_unit_test.sv
`timescale 1ns/1ps
module mdu_acc_unit_test;
  localparam int W   = 8;
  localparam int LAT = 2;
  localparam int AW  = 2 * W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_op = '0;
  logic [W-1:0] req_a = '0, req_b = '0;
  logic         busy, res_valid;
  logic         res_ready = 1'b0;
  logic [W-1:0] res_data;

  int n_chk = 0, n_bad = 0;
  int cycles = 0;
  logic [AW-1:0] ref_acc = '0;
  logic [W-1:0]  divisors [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07,
                                   8'h40, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};

  mdu_acc_unit #(.DATA_W(W), .MUL_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data));

  always #10 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // accept one request, then return how many cycles busy stayed high
  task automatic issue(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, output int bcyc, output bit rdy_leak);
    bit seen;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    do begin
      seen = req_ready;
      @(negedge clk);
    end while (!seen);
    req_valid = 1'b0;
    bcyc = 0; rdy_leak = 0;
    while (busy) begin
      bcyc++;
      if (req_ready) rdy_leak = 1;
      @(negedge clk);
    end
  endtask

  task automatic take_res(output logic [W-1:0] d);
    while (!res_valid) @(negedge clk);
    d = res_data;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic read_acc(output logic [AW-1:0] v);
    int bc; bit lk; logic [W-1:0] h, l;
    issue(4'd11, '0, '0, bc, lk); take_res(h);
    issue(4'd12, '0, '0, bc, lk); take_res(l);
    v = {h, l};
  endtask

  function automatic logic [AW-1:0] prod(logic [W-1:0] a, logic [W-1:0] b, bit sgn);
    longint pa, pb;
    pa = sgn ? longint'($signed(a)) : longint'(a);
    pb = sgn ? longint'($signed(b)) : longint'(b);
    return AW'(pa * pb);
  endfunction

  initial begin
    int bc; bit lk;
    logic [AW-1:0] got;
    logic [W-1:0] d, d0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 res_valid", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_acc(got);
    check("R1 acc zero", 64'(got), 64'd0);

    // R10: moves into each half
    issue(4'd9, 8'hA5, 8'h00, bc, lk);
    check("R10 no busy on write-HI", 64'(bc), 64'd0);
    read_acc(got);
    check("R10 HI written LO kept", 64'(got), 64'hA500);
    issue(4'd10, 8'h3C, 8'h00, bc, lk);
    check("R10 no busy on write-LO", 64'(bc), 64'd0);
    read_acc(got);
    check("R10 LO written HI kept", 64'(got), 64'hA53C);

    // R12: spare codes ignored
    for (int c = 13; c < 16; c++) begin
      issue(4'(c), 8'h11, 8'h22, bc, lk);
      check("R12 no busy", 64'(bc), 64'd0);
      check("R12 no result", 64'(res_valid), 64'd0);
    end
    read_acc(got);
    check("R12 acc unchanged", 64'(got), 64'hA53C);

    // R3 / R2: result held under back-pressure
    issue(4'd11, '0, '0, bc, lk);
    d0 = res_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 res_valid held", 64'(res_valid), 64'd1);
      check("R3 res_data stable", 64'(res_data), 64'(d0));
      check("R2 no accept while result pending", 64'(req_ready), 64'd0);
    end
    take_res(d);
    check("R11 read-HI value", 64'(d), 64'hA5);

    // R4 / R5: multiply family over a grid, running accumulator
    ref_acc = 16'hA53C;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [W-1:0] a, b; int opc; bit sg;
        a = W'(i * 17 + (j & 1) * 8);
        b = W'(j * 17 + 5);
        opc = (i + j) % 6;
        sg = (opc % 2) == 0;
        issue(4'(opc), a, b, bc, lk);
        check("R4 multiply busy cycles", 64'(bc), 64'(LAT));
        case (opc / 2)
          0: ref_acc = prod(a, b, sg);
          1: ref_acc = ref_acc + prod(a, b, sg);
          default: ref_acc = ref_acc - prod(a, b, sg);
        endcase
        read_acc(got);
        check(opc < 2 ? "R4 product" : "R5 accumulate", 64'(got), 64'(ref_acc));
      end
    end

    // R6: short multiply returns low word, accumulator untouched
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a, b; logic [AW-1:0] p;
      a = W'(i * 37 + 128); b = W'(255 - i * 29);
      p = prod(a, b, 1'b1);
      issue(4'd8, a, b, bc, lk);
      check("R6 busy cycles", 64'(bc), 64'(LAT));
      check("R6 result ready with busy drop", 64'(res_valid), 64'd1);
      take_res(d);
      check("R6 low product", 64'(d), 64'(p[W-1:0]));
      read_acc(got);
      check("R6 acc unchanged", 64'(got), 64'(ref_acc));
    end

    // R7 / R8 / R9: every dividend against awkward divisors
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        foreach (divisors[k]) begin
          logic [W-1:0] b, eq, er; int sa, sb;
          b = divisors[k];
          if (b == 0) begin
            eq = '1; er = W'(a);
          end else if (s == 1) begin
            sa = int'($signed(W'(a))); sb = int'($signed(b));
            eq = W'(sa / sb); er = W'(sa % sb);
          end else begin
            eq = W'(a / int'(b)); er = W'(a % int'(b));
          end
          issue(s == 1 ? 4'd6 : 4'd7, W'(a), b, bc, lk);
          check("R7 divide busy cycles", 64'(bc), 64'(W));
          check("R11 req_ready low while busy", 64'(lk), 64'd0);
          read_acc(got);
          if (b == 0)      check("R9 divide by zero", 64'(got), 64'({er, eq}));
          else if (s == 1) check("R8 signed divide", 64'(got), 64'({er, eq}));
          else             check("R7 unsigned divide", 64'(got), 64'({er, eq}));
        end
      end
    end

    // R8: most negative over -1 spelled out
    issue(4'd6, 8'h80, 8'hFF, bc, lk);
    read_acc(got);
    check("R8 min over minus one", 64'(got), 64'h0080);

    // R11: read issued right behind a divide waits for it
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd7; req_a = 8'd200; req_b = 8'd7;
    @(negedge clk);
    req_op = 4'd12;
    bc = 0;
    while (!req_ready) begin bc++; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 read stalled for divide", 64'(bc), 64'(W));
    take_res(d);
    check("R11 read after divide", 64'(d), 64'd28);

    summary();
  end
endmodule